// File: doc/BRIEF.md
# MDIO Management Master

This block lets software reach the management registers of external Ethernet PHYs over a two-wire management bus. It has a small register bank on a plain word-addressed write/read port. From that bank it builds Clause 22 frames. It drives the management clock and the bidirectional data pin through separate output and output-enable pins, and it captures the 16-bit reply of a read.

A write frame starts when software writes the transmit-data register. A read frame starts when the read bit of the command register goes from 0 to 1. The management clock is a divided copy of the system clock. A 4-bit index selects the divisor from a fixed non-linear table: 4, 4, 6, 8, 10, 14, 20, 28, 34, 42, 50, 58, 66, 74, 82, 98 for indices 0 to 15. Software polls a busy register to find when a frame is done.

The register port has no back-pressure. A write strobe always completes in the cycle it is presented. Read data is a combinational function of the address, so it is valid in the same cycle. Because no data stream crosses the block edge, there is no valid/ready pair.

Register map (word addresses):

| Address | Register | Contents |
|---|---|---|
| 0 | Configuration | divider index in bits 3:0; soft-reset bit in bit 31 |
| 1 | Target | PHY field in bits 15:8; register number in bits 7:0 |
| 2 | Command | read bit in bit 0 |
| 3 | Transmit data | write value in bits 15:0 |
| 4 | Read result | captured reply in bits 15:0 |
| 5 | Busy | 1 in bit 0 while a frame runs |

Top module: `mdio_mgmt_top`

## Requirements
- R1: After reset, every register reads 0, MDC is low and the output enable is low.
- R2: When the block is idle, a write to address 3 sends one 64-bit frame on mdio_o, read at each rising MDC edge. The frame is 32 ones, then 01, then opcode 01, then the 5-bit PHY address, then the 5-bit register number, then 10, then the 16 data bits with the MSB first. mdio_oe is high for all 64 bits.
- R3: When the block is idle, a 0-to-1 change of command bit 0 sends a read frame. Its first 46 bits match R2 except that the opcode is 10. mdio_oe goes low from bit 46 (turnaround) up to the end of the frame.
- R4: During a read frame, mdio_i is sampled on the rising MDC edges of bits 48 to 63, MSB first. The 16-bit value appears in bits 15:0 of address 4 after the frame. A write frame leaves address 4 unchanged.
- R5: Bit 0 of address 5 reads 1 from the clock edge that accepts a trigger write until the frame ends, and 0 otherwise.
- R6: A trigger write (address 3, or a 0-to-1 change of command bit 0) made while a frame runs is ignored. The running frame goes on unchanged and no second frame follows.
- R7: Writing 1 to command bit 0 while it already holds 1 starts no frame.
- R8: MDC is low while idle. During a frame, each high phase and each low phase lasts half the divisor in system clock cycles. The divisor is the table entry selected by configuration bits 3:0. Indices 0 and 1 both give 4.
- R9: mdio_o changes only while MDC is low. It never changes while MDC is high.
- R10: While configuration bit 31 is set, any running frame is aborted: busy reads 0 and MDC is low. Triggers are ignored. After bit 31 is cleared, frames work again.
- R11: Only bits 12:8 (PHY address) and bits 4:0 (register number) of address 1 go into the frame. The other bits of each field are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe, one cycle per write |
| csr_addr | input | 3 | Register word address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for csr_addr, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | High when mdio_o should drive the pin |
| mdio_i | input | 1 | Management data sampled from the pin |

## Verification
Some properties are checked on every cycle: MDC stays low and the pin is released whenever no frame runs; mdio_o holds still through every MDC high phase; busy rises on the edge after an accepted trigger; and the soft-reset bit forces the block idle. Other behaviour only the directed scenarios can show. These cover the exact 64-bit frame contents, the turnaround release point, the captured read value, the phase lengths for several table indices, and triggers that are dropped while busy or at the 1-to-1 command level. They also cover an abort followed by recovery.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int IDX_W    = 4;
  localparam int DIV_W    = 7;
  localparam int FRAME_LEN = 64;
  localparam int PRE_LEN  = 32;
  localparam int FIELD_W  = 5;
  localparam int DATA_W   = 16;
  localparam int CSR_AW   = 3;
  localparam int CSR_DW   = 32;
  localparam int TA_POS   = PRE_LEN + 4 + 2 * FIELD_W;
  localparam int DATA_POS = TA_POS + 2;

  typedef enum logic [CSR_AW-1:0] {
    CSR_CFG   = 3'd0,
    CSR_ADDR  = 3'd1,
    CSR_CMD   = 3'd2,
    CSR_WDATA = 3'd3,
    CSR_RDATA = 3'd4,
    CSR_BUSY  = 3'd5
  } csr_sel_e;

  // Divisor selected by the index; all entries even so halves are exact.
  function automatic logic [DIV_W-1:0] mdc_divisor(input logic [IDX_W-1:0] idx);
    logic [DIV_W-1:0] d;
    case (idx)
      4'd0:  d = 7'd4;
      4'd1:  d = 7'd4;
      4'd2:  d = 7'd6;
      4'd3:  d = 7'd8;
      4'd4:  d = 7'd10;
      4'd5:  d = 7'd14;
      4'd6:  d = 7'd20;
      4'd7:  d = 7'd28;
      4'd8:  d = 7'd34;
      4'd9:  d = 7'd42;
      4'd10: d = 7'd50;
      4'd11: d = 7'd58;
      4'd12: d = 7'd66;
      4'd13: d = 7'd74;
      4'd14: d = 7'd82;
      default: d = 7'd98;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen
  import mdio_mgmt_pkg::*;
#(
  parameter int SEL_W = IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] div_idx,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);

  localparam int HALF_W = DIV_W - 1;

  logic [DIV_W-1:0]  div_full;
  logic [HALF_W-1:0] half_q;
  logic [HALF_W-1:0] cnt_q;
  logic              mdc_q;
  logic              phase_end;

  assign div_full  = mdc_divisor(div_idx);
  assign phase_end = (cnt_q == half_q - 1'b1);

  // The half period is latched while idle so a frame runs at one rate.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= HALF_W'(2);
      cnt_q  <= '0;
      mdc_q  <= 1'b0;
    end else if (!run) begin
      half_q <= div_full[DIV_W-1:1];
      cnt_q  <= '0;
      mdc_q  <= 1'b0;
    end else if (phase_end) begin
      cnt_q  <= '0;
      mdc_q  <= ~mdc_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign mdc      = mdc_q;
  assign rise_stb = run && phase_end && !mdc_q;
  assign fall_stb = run && phase_end && mdc_q;

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
#(
  parameter int FLEN = FRAME_LEN,
  parameter int FW   = FIELD_W,
  parameter int DW   = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          launch_wr,
  input  logic          launch_rd,
  input  logic [FW-1:0] phy_addr,
  input  logic [FW-1:0] reg_addr,
  input  logic [DW-1:0] wr_value,
  input  logic          rise_stb,
  input  logic          fall_stb,
  input  logic          mdio_i,
  output logic          busy,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic          rd_done,
  output logic [DW-1:0] rd_value
);

  localparam int BIT_W = $clog2(FLEN);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FLEN - 1);
  localparam logic [BIT_W-1:0] PRE_TA   = BIT_W'(TA_POS - 1);
  localparam logic [BIT_W-1:0] FIRST_D  = BIT_W'(DATA_POS);

  logic [FLEN-1:0]  frame_d;
  logic [FLEN-1:0]  shreg_q;
  logic [BIT_W-1:0] bit_q;
  logic             busy_q;
  logic             is_rd_q;
  logic             out_q;
  logic             oe_q;
  logic             done_q;
  logic [DW-1:0]    cap_q;

  assign frame_d = {{PRE_LEN{1'b1}}, 2'b01,
                    (launch_rd ? 2'b10 : 2'b01),
                    phy_addr, reg_addr, 2'b10,
                    (launch_rd ? {DW{1'b0}} : wr_value)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      is_rd_q <= 1'b0;
      shreg_q <= '0;
      bit_q   <= '0;
      out_q   <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      cap_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (srst) begin
        busy_q <= 1'b0;
        oe_q   <= 1'b0;
      end else if (!busy_q && (launch_wr || launch_rd)) begin
        busy_q  <= 1'b1;
        is_rd_q <= launch_rd;
        shreg_q <= frame_d;
        bit_q   <= '0;
        out_q   <= frame_d[FLEN-1];
        oe_q    <= 1'b1;
      end else if (busy_q) begin
        if (rise_stb && is_rd_q && (bit_q >= FIRST_D)) begin
          cap_q <= {cap_q[DW-2:0], mdio_i};
        end
        if (fall_stb) begin
          if (bit_q == LAST_BIT) begin
            busy_q <= 1'b0;
            oe_q   <= 1'b0;
            done_q <= is_rd_q;
          end else begin
            bit_q   <= bit_q + 1'b1;
            shreg_q <= {shreg_q[FLEN-2:0], 1'b0};
            out_q   <= shreg_q[FLEN-2];
            if (is_rd_q && (bit_q == PRE_TA)) begin
              oe_q <= 1'b0;
            end
          end
        end
      end
    end
  end

  assign busy     = busy_q;
  assign mdio_o   = out_q;
  assign mdio_oe  = oe_q;
  assign rd_done  = done_q;
  assign rd_value = cap_q;

endmodule

// File: rtl/mdio_csr_bank.sv
module mdio_csr_bank
  import mdio_mgmt_pkg::*;
#(
  parameter int AW = CSR_AW,
  parameter int DW = CSR_DW,
  parameter int SEL_W = IDX_W,
  parameter int FW = FIELD_W,
  parameter int VW = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we,
  input  logic [AW-1:0]    csr_addr,
  input  logic [DW-1:0]    csr_wdata,
  output logic [DW-1:0]    csr_rdata,
  input  logic             seq_busy,
  input  logic             rd_done,
  input  logic [VW-1:0]    rd_value,
  output logic [SEL_W-1:0] div_idx,
  output logic             srst,
  output logic             launch_wr,
  output logic             launch_rd,
  output logic [FW-1:0]    phy_addr,
  output logic [FW-1:0]    reg_addr,
  output logic [VW-1:0]    wr_value
);

  localparam int SRST_BIT = DW - 1;

  logic [SEL_W-1:0] idx_q;
  logic             srst_q;
  logic [7:0]       phy_q;
  logic [7:0]       reg_q;
  logic             cmd_q;
  logic [VW-1:0]    wdata_q;
  logic [VW-1:0]    rdata_q;
  logic             can_start;
  logic             hit_cfg, hit_addr, hit_cmd, hit_wdata;

  assign hit_cfg   = csr_we && (csr_addr == CSR_CFG);
  assign hit_addr  = csr_we && (csr_addr == CSR_ADDR);
  assign hit_cmd   = csr_we && (csr_addr == CSR_CMD);
  assign hit_wdata = csr_we && (csr_addr == CSR_WDATA);

  assign can_start = !seq_busy && !srst_q;
  assign launch_wr = hit_wdata && can_start;
  assign launch_rd = hit_cmd && csr_wdata[0] && !cmd_q && can_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      srst_q  <= 1'b0;
      phy_q   <= '0;
      reg_q   <= '0;
      cmd_q   <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (hit_cfg) begin
        idx_q  <= csr_wdata[SEL_W-1:0];
        srst_q <= csr_wdata[SRST_BIT];
      end
      if (hit_addr) begin
        phy_q <= csr_wdata[15:8];
        reg_q <= csr_wdata[7:0];
      end
      if (hit_cmd) begin
        cmd_q <= csr_wdata[0];
      end
      if (launch_wr) begin
        wdata_q <= csr_wdata[VW-1:0];
      end
      if (rd_done) begin
        rdata_q <= rd_value;
      end
    end
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      CSR_CFG:   csr_rdata = {srst_q, {(DW-1-SEL_W){1'b0}}, idx_q};
      CSR_ADDR:  csr_rdata = {{(DW-16){1'b0}}, phy_q, reg_q};
      CSR_CMD:   csr_rdata = {{(DW-1){1'b0}}, cmd_q};
      CSR_WDATA: csr_rdata = {{(DW-VW){1'b0}}, wdata_q};
      CSR_RDATA: csr_rdata = {{(DW-VW){1'b0}}, rdata_q};
      CSR_BUSY:  csr_rdata = {{(DW-1){1'b0}}, seq_busy};
      default:   csr_rdata = '0;
    endcase
  end

  assign div_idx  = idx_q;
  assign srst     = srst_q;
  assign phy_addr = phy_q[FW-1:0];
  assign reg_addr = reg_q[FW-1:0];
  assign wr_value = csr_wdata[VW-1:0];

endmodule

// File: rtl/mdio_mgmt_top.sv
module mdio_mgmt_top
  import mdio_mgmt_pkg::*;
#(
  parameter int AW = CSR_AW,
  parameter int DW = CSR_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csr_we,
  input  logic [AW-1:0] csr_addr,
  input  logic [DW-1:0] csr_wdata,
  output logic [DW-1:0] csr_rdata,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic          mdio_i
);

  logic [IDX_W-1:0]   div_idx;
  logic               cfg_srst;
  logic               launch_wr, launch_rd;
  logic [FIELD_W-1:0] phy_addr, reg_addr;
  logic [DATA_W-1:0]  wr_value, rd_value;
  logic               seq_busy, rd_done;
  logic               rise_stb, fall_stb;

  mdio_csr_bank #(.AW(AW), .DW(DW)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .seq_busy(seq_busy), .rd_done(rd_done), .rd_value(rd_value),
    .div_idx(div_idx), .srst(cfg_srst),
    .launch_wr(launch_wr), .launch_rd(launch_rd),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_value(wr_value)
  );

  mdio_clk_gen u_clk (
    .clk(clk), .rst_n(rst_n),
    .run(seq_busy && !cfg_srst), .div_idx(div_idx),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .srst(cfg_srst),
    .launch_wr(launch_wr), .launch_rd(launch_rd),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_value(wr_value),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
    .busy(seq_busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_done(rd_done), .rd_value(rd_value)
  );

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker
  import mdio_mgmt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              csr_we,
  input logic [CSR_AW-1:0] csr_addr,
  input logic              busy,
  input logic              srst,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe
);

  assert_idle_mdc_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  assert_wr_trigger_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == CSR_WDATA && !busy && !srst) |=> busy);

  assert_data_hold_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> $stable(mdio_o));

  assert_soft_reset_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !busy);

endmodule

bind mdio_mgmt_top mdio_mgmt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
  .busy(seq_busy), .srst(cfg_srst), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/sim_mdio_mgmt_top.sv
module sim_mdio_mgmt_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [2:0]  csr_addr = 3'd5;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int tests = 0;
  int fails = 0;

  logic [63:0] cap_o = '0;
  logic [63:0] cap_oe = '0;
  int          cap_cnt = 0;
  logic [63:0] reply = '0;
  int          run_len = 0, hi_len = 0, lo_len = 0, hold_err = 0;
  logic        prev_mdc = 1'b0, prev_o = 1'b0;

  always #5 clk = ~clk;

  mdio_mgmt_top u0 (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model: presents reply bit k while the k-th rising MDC edge is awaited.
  assign mdio_i = (cap_cnt < 64) ? reply[63 - cap_cnt] : 1'b1;

  always @(posedge mdc) begin
    cap_o   <= {cap_o[62:0], mdio_o};
    cap_oe  <= {cap_oe[62:0], mdio_oe};
    cap_cnt <= cap_cnt + 1;
  end

  always @(negedge clk) begin
    if (mdc == prev_mdc) run_len = run_len + 1;
    else begin
      if (prev_mdc) hi_len = run_len; else lo_len = run_len;
      run_len = 1;
    end
    if (mdc && prev_mdc && (mdio_o != prev_o)) hold_err = hold_err + 1;
    prev_mdc = mdc;
    prev_o   = mdio_o;
  end

  function automatic int div_for(input int idx);
    int t[16] = '{4, 4, 6, 8, 10, 14, 20, 28, 34, 42, 50, 58, 66, 74, 82, 98};
    return t[idx];
  endfunction

  function automatic logic [63:0] frame_of(input bit rd, input logic [4:0] phy,
                                           input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, d};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0; csr_addr = 3'd5;
  endtask

  task automatic csr_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    #1 d = csr_rdata;
    csr_addr = 3'd5;
  endtask

  task automatic wait_idle();
    logic [31:0] b;
    for (int i = 0; i < 20000; i++) begin
      csr_read(3'd5, b);
      if (b[0] == 1'b0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 6; a++) begin
      csr_read(a[2:0], v);
      check("R1 register reset value", v, 64'd0);
    end
    check("R1 mdc low", {63'd0, mdc}, 64'd0);
    check("R1 oe low", {63'd0, mdio_oe}, 64'd0);
  endtask

  task automatic t_write(input int idx, input logic [7:0] phy, input logic [7:0] rg,
                         input logic [15:0] d);
    logic [31:0] v;
    csr_write(3'd0, idx);
    csr_write(3'd1, {16'd0, phy, rg});
    cap_cnt = 0; hold_err = 0;
    csr_write(3'd3, {16'd0, d});
    #1 check("R5 busy on accepting edge", {63'd0, csr_rdata[0]}, 64'd1);
    wait_idle();
    check("R2 bit count", cap_cnt, 64'd64);
    check("R2 R11 write frame", cap_o, frame_of(1'b0, phy[4:0], rg[4:0], d));
    check("R2 oe all frame", cap_oe, {64{1'b1}});
    check("R9 data stable while mdc high", hold_err, 64'd0);
    check("R8 high phase", hi_len, div_for(idx) / 2);
    check("R8 low phase", lo_len, div_for(idx) / 2);
    check("R8 idle low", {63'd0, mdc}, 64'd0);
    csr_read(3'd5, v);
    check("R5 busy cleared", v, 64'd0);
  endtask

  task automatic t_read(input logic [7:0] phy, input logic [7:0] rg, input logic [15:0] val);
    logic [31:0] v;
    csr_write(3'd2, 32'd0);
    csr_write(3'd1, {16'd0, phy, rg});
    reply = {48'd0, val};
    cap_cnt = 0;
    csr_write(3'd2, 32'd1);
    #1 check("R3 R5 busy after read trigger", {63'd0, csr_rdata[0]}, 64'd1);
    wait_idle();
    check("R3 bit count", cap_cnt, 64'd64);
    check("R3 read header", {18'd0, cap_o[63:18]},
          {18'd0, frame_of(1'b1, phy[4:0], rg[4:0], 16'd0) >> 18});
    check("R3 release at turnaround", cap_oe, {{46{1'b1}}, 18'd0});
    csr_read(3'd4, v);
    check("R4 captured read data", v, {48'd0, val});
    csr_write(3'd2, 32'd0);
  endtask

  task automatic t_write_keeps_rdata(input logic [15:0] prior);
    logic [31:0] v;
    t_write(0, 8'h01, 8'h02, 16'h1357);
    csr_read(3'd4, v);
    check("R4 write leaves read result", v, {48'd0, prior});
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    csr_write(3'd0, 32'd0);
    csr_write(3'd2, 32'd0);
    csr_write(3'd1, 32'h0000_0305);
    cap_cnt = 0;
    csr_write(3'd3, 32'h0000_ABCD);
    repeat (20) @(negedge clk);
    csr_write(3'd3, 32'h0000_1111);
    csr_write(3'd2, 32'd1);
    wait_idle();
    repeat (10) @(negedge clk);
    check("R6 running frame unchanged", cap_o, frame_of(1'b0, 5'd3, 5'd5, 16'hABCD));
    check("R6 no second frame", cap_cnt, 64'd64);
    csr_read(3'd5, v);
    check("R6 idle after ignored triggers", v, 64'd0);
    csr_write(3'd2, 32'd0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    csr_write(3'd2, 32'd1);
    wait_idle();
    cap_cnt = 0;
    csr_write(3'd2, 32'd1);
    #1 check("R7 no start at 1 to 1", {63'd0, csr_rdata[0]}, 64'd0);
    repeat (20) @(negedge clk);
    check("R7 no mdc edges", cap_cnt, 64'd0);
    csr_write(3'd2, 32'd0);
  endtask

  task automatic t_soft_reset();
    logic [31:0] v;
    csr_write(3'd0, 32'd0);
    cap_cnt = 0;
    csr_write(3'd3, 32'h0000_5A5A);
    repeat (40) @(negedge clk);
    csr_write(3'd0, 32'h8000_0000);
    @(negedge clk);
    csr_read(3'd5, v);
    check("R10 abort clears busy", v, 64'd0);
    check("R10 abort leaves mdc low", {63'd0, mdc}, 64'd0);
    csr_write(3'd3, 32'h0000_0F0F);
    #1 check("R10 trigger ignored in soft reset", {63'd0, csr_rdata[0]}, 64'd0);
    csr_write(3'd0, 32'd0);
    cap_cnt = 0;
    csr_write(3'd3, 32'h0000_C3C3);
    wait_idle();
    check("R10 recovery frame", cap_o, frame_of(1'b0, 5'd3, 5'd5, 16'hC3C3));
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(1, 8'hE3, 8'h7A, 16'hBEEF);
    t_write(5, 8'h11, 8'h1F, 16'h8001);
    t_read(8'h05, 8'h09, 16'hA5C3);
    t_write_keeps_rdata(16'hA5C3);
    t_busy_ignore();
    t_level();
    t_soft_reset();
    t_write(15, 8'h1F, 8'h00, 16'h0F0F);
    finish_run();
  end

endmodule